// File: doc/BRIEF.md
# Edge-Timestamp Capture Unit with Glitch Filter

This block timestamps transitions on an asynchronous input line. A free-running 16-bit count is supplied from outside. When the line makes a transition of the selected direction, the block copies that count into a capture register. In the same clock it raises a flag that lasts exactly one cycle. The capture register keeps its value until the next accepted transition replaces it.

Two static controls set the behaviour. One chooses whether falling or rising transitions are captured. The other enables a glitch filter. With the filter on, a new level must appear in four consecutive system-clock samples before the transition counts. The raw line always passes through a two-flop synchroniser first. Because of this, the delay from the line to the flag is a fixed number of clocks in each filter setting. A change on either control blanks edge detection for two clocks. This keeps the change itself from being reported as a transition.

Top module: `icap_unit`

## Requirements
- R1: With `filt_en`=0, the first sampled transition of the selected direction is captured. `cap_flag` rises exactly 3 clock edges after the first edge that samples the new pin level.
- R2: With `filt_en`=1, a transition is captured only after 4 consecutive synchronised samples at the new level. `cap_flag` rises exactly 6 clock edges after the first edge that samples the new pin level.
- R3: With `filt_en`=1, a pulse at the new level that lasts 3 or fewer clock samples produces no capture.
- R4: With `edge_rise`=0, only 1-to-0 transitions are captured. With `edge_rise`=1, only 0-to-1 transitions are captured. The opposite direction never raises `cap_flag`.
- R5: On a capture, `cap_val` takes all 16 bits of the `cnt_in` value present at the clock edge that raises `cap_flag`.
- R6: `cap_flag` is high for exactly one clock per accepted transition.
- R7: `cap_val` stays unchanged in every cycle where `cap_flag` is low.
- R8: While `rst_n` is low, `cap_val` reads 0 and `cap_flag` reads 0. The internal sample history is cleared to the low level, and the control history is cleared to filter off and falling edge.
- R9: A change on `edge_rise` or `filt_en` blocks capture for the two following clocks. A level jump caused by switching the filter off is not reported as a transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the filter sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous line being watched |
| cnt_in | input | 16 | Free-running count to be timestamped |
| filt_en | input | 1 | 1 = four-sample glitch filter enabled |
| edge_rise | input | 1 | 1 = capture rising transitions, 0 = falling |
| cap_val | output | 16 | Most recent captured count |
| cap_flag | output | 1 | One-clock pulse when `cap_val` updates |

## Verification
The bench measures the exact clock count from a pin change to the flag in both filter settings. A wrong pipeline depth therefore shows up as a latency or timestamp mismatch, not as a silent shift. It sends a 3-sample pulse and a 4-sample pulse through the filter. This separates a filter that is one stage short, which accepts the 3-sample pulse, from one that is one stage long, which drops the 4-sample pulse. It drives transitions in the direction that is not selected. A design with the polarity decode inverted or ignored would capture them. It also switches the filter off while a new level is still in the filter window. A design that does not blank after a control change would report that jump as a capture.

// File: rtl/icap_pkg.sv
package icap_pkg;

   // Direction of the line transition that triggers a capture.
   typedef enum logic {
      POL_FALL = 1'b0,
      POL_RISE = 1'b1
   } pol_e;

   // Number of clocks from the first edge that samples the pin to the edge
   // that raises the capture flag.
   function automatic int unsigned lat_plain(input int unsigned sync_stages);
      return sync_stages + 1;
   endfunction

   function automatic int unsigned lat_filtered(input int unsigned sync_stages,
                                                input int unsigned depth);
      return sync_stages + depth;
   endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("icap_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
   parameter int unsigned DEPTH      = 4,
   parameter bit          HAS_FILTER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic filt_en,
   output logic lvl
);

   localparam int unsigned HIST_W = DEPTH - 1;

   generate
      if (DEPTH < 2) begin : g_bad
         $error("icap_filter: DEPTH must be at least 2");
      end

      if (HAS_FILTER) begin : g_filt
         logic [HIST_W-1:0] hist;
         logic [DEPTH-1:0]  win;
         logic              lvl_nx;

         // Window = stored history plus the sample arriving this cycle.
         assign win = {hist, din};

         always_comb begin
            if (!filt_en) begin
               lvl_nx = din;
            end else if (&win) begin
               lvl_nx = 1'b1;
            end else if (~|win) begin
               lvl_nx = 1'b0;
            end else begin
               lvl_nx = lvl;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist <= '0;
               lvl  <= 1'b0;
            end else begin
               hist <= win[HIST_W-1:0];
               lvl  <= lvl_nx;
            end
         end
      end else begin : g_plain
         logic unused_en;
         assign unused_en = filt_en;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl <= 1'b0;
            end else begin
               lvl <= din;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/icap_edge.sv
module icap_edge
   import icap_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rise_sel,
   input  logic filt_en,
   output logic hit
);

   logic prev;
   pol_e pol_q;
   logic fen_q;
   logic chg_now;
   logic chg_q;
   logic rise_seen;
   logic fall_seen;

   // A control change blanks detection this cycle and the next, so a level
   // jump caused by the change settles into prev before it can be seen.
   assign chg_now = (pol_e'(rise_sel) != pol_q) || (filt_en != fen_q);

   assign rise_seen = lvl & ~prev;
   assign fall_seen = ~lvl & prev;

   always_comb begin
      hit = 1'b0;
      if (!chg_now && !chg_q) begin
         unique case (pol_e'(rise_sel))
            POL_RISE: hit = rise_seen;
            POL_FALL: hit = fall_seen;
            default:  hit = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= 1'b0;
         pol_q <= POL_FALL;
         fen_q <= 1'b0;
         chg_q <= 1'b0;
      end else begin
         prev  <= lvl;
         pol_q <= pol_e'(rise_sel);
         fen_q <= filt_en;
         chg_q <= chg_now;
      end
   end

endmodule

// File: rtl/icap_capture.sv
module icap_capture #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hit,
   input  logic [W-1:0] cnt,
   output logic [W-1:0] cap_val,
   output logic         cap_flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val  <= '0;
         cap_flag <= 1'b0;
      end else begin
         cap_flag <= hit;
         if (hit) begin
            cap_val <= cnt;
         end
      end
   end

endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_DEPTH  = 4,
   parameter bit          HAS_FILTER  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic [CNT_W-1:0] cnt_in,
   input  logic             filt_en,
   input  logic             edge_rise,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_flag
);

   localparam int unsigned LAT_PLAIN = icap_pkg::lat_plain(SYNC_STAGES);
   localparam int unsigned LAT_FILT  = icap_pkg::lat_filtered(SYNC_STAGES, FILT_DEPTH);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("icap_unit: CNT_W must be positive");
      end
      if (LAT_FILT <= LAT_PLAIN) begin : g_bad_lat
         $error("icap_unit: filtered latency must exceed plain latency");
      end
   endgenerate

   logic pin_s;
   logic lvl;
   logic hit;

   icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   icap_filter #(.DEPTH(FILT_DEPTH), .HAS_FILTER(HAS_FILTER)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (pin_s),
      .filt_en (filt_en),
      .lvl     (lvl)
   );

   icap_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl),
      .rise_sel (edge_rise),
      .filt_en  (filt_en),
      .hit      (hit)
   );

   icap_capture #(.W(CNT_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .cnt      (cnt_in),
      .cap_val  (cap_val),
      .cap_flag (cap_flag)
   );

endmodule

// File: rtl/icap_chk.sv
module icap_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt_in,
   input logic             filt_en,
   input logic             edge_rise,
   input logic [CNT_W-1:0] cap_val,
   input logic             cap_flag
);

   // R5
   cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_flag |-> (cap_val == $past(cnt_in)));

   // R6
   flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_flag |=> !cap_flag);

   // R7
   value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_flag |-> $stable(cap_val));

   // R9
   ctrl_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((edge_rise != $past(edge_rise)) || (filt_en != $past(filt_en))) |=> !cap_flag);

endmodule

bind icap_unit icap_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_in    (cnt_in),
   .filt_en   (filt_en),
   .edge_rise (edge_rise),
   .cap_val   (cap_val),
   .cap_flag  (cap_flag)
);

// File: tb/tb_icap_unit.sv
module tb_icap_unit;

   localparam int LAT_P = 3;
   localparam int LAT_F = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_in = 1'b0;
   logic        filt_en = 1'b0;
   logic        edge_rise = 1'b0;
   logic [15:0] cnt_in = 16'd0;
   logic [15:0] cap_val;
   logic        cap_flag;

   int checks = 0;
   int fails  = 0;

   icap_unit dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (pin_in),
      .cnt_in    (cnt_in),
      .filt_en   (filt_en),
      .edge_rise (edge_rise),
      .cap_val   (cap_val),
      .cap_flag  (cap_flag)
   );

   always #5 clk = ~clk;

   // Count moves 1 ns after each rising edge, so it is stable at the edges.
   always @(posedge clk) cnt_in <= #1 cnt_in + 16'd1;

   // Vector bits: {filt_en, edge_rise, new pin level, capture expected}
   localparam int NV = 9;
   localparam logic [3:0] VEC [NV] = '{
      4'b0010,  // R4: rising transition while falling selected
      4'b0001,  // R1: falling transition captured
      4'b0111,  // R1: rising transition captured
      4'b0100,  // R4: falling transition while rising selected
      4'b1111,  // R2: filtered rising transition
      4'b1100,  // R4: filtered falling, rising selected
      4'b1010,  // R4: filtered rising, falling selected
      4'b1001,  // R2: filtered falling transition
      4'b0111   // R1: rising again, filter off
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Pin changes at a falling edge. flip_at toggles the pin and fen_at
   // toggles filt_en after that many rising edges.
   task automatic stim(input logic lvl, input bit exp_cap, input int lat,
                       input int flip_at, input int fen_at, input string req);
      int          hits = 0;
      int          at = -1;
      logic [15:0] got = 16'd0;
      logic [15:0] v;
      logic [15:0] expv;
      @(negedge clk);
      pin_in = lvl;
      v = cnt_in;
      for (int n = 0; n < 12; n++) begin
         @(negedge clk);
         if (cap_flag) begin
            hits++;
            if (at < 0) begin
               at  = n;
               got = cap_val;
            end
         end
         if (n == flip_at) pin_in = ~pin_in;
         if (n == fen_at) filt_en = ~filt_en;
      end
      if (exp_cap) begin
         expv = v + 16'(lat);
         chk(hits == 1, req, "flag pulse count (R6)", hits, 1);
         chk(at == lat, req, "edge-to-flag latency", at, lat);
         chk(got == expv, req, "captured count (R5)", int'(got), int'(expv));
      end else begin
         chk(hits == 0, req, "spurious capture", hits, 0);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [15:0] held;
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(cap_val == 16'd0, "R8", "cap_val in reset", int'(cap_val), 0);
      chk(cap_flag == 1'b0, "R8", "cap_flag in reset", int'(cap_flag), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         filt_en   = VEC[i][3];
         edge_rise = VEC[i][2];
         repeat (3) @(negedge clk);
         stim(VEC[i][1], VEC[i][0], VEC[i][3] ? LAT_F : LAT_P, -1, -1,
              VEC[i][0] ? (VEC[i][3] ? "R2" : "R1") : "R4");
      end

      // R7: falling transition with rising selected, value must hold
      held = cap_val;
      stim(1'b0, 1'b0, LAT_P, -1, -1, "R7");
      repeat (10) @(negedge clk);
      chk(cap_val == held, "R7", "value held", int'(cap_val), int'(held));

      // R3: filtered 3-sample pulse rejected, 4-sample pulse accepted (R2)
      @(negedge clk);
      filt_en = 1'b1;
      repeat (3) @(negedge clk);
      stim(1'b1, 1'b0, LAT_F, 2, -1, "R3");
      stim(1'b1, 1'b1, LAT_F, 3, -1, "R2");

      // R1: single-sample pulse with filter off is captured
      @(negedge clk);
      filt_en = 1'b0;
      repeat (3) @(negedge clk);
      stim(1'b1, 1'b1, LAT_P, 0, -1, "R1");
      pin_in = 1'b0;
      repeat (4) @(negedge clk);

      // R9: filter switched off while the new level sits in its window
      @(negedge clk);
      filt_en = 1'b1;
      repeat (3) @(negedge clk);
      stim(1'b1, 1'b0, LAT_F, -1, 1, "R9");

      // R8: reset in mid run clears the captured value
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(cap_val == 16'd0, "R8", "cap_val after reset", int'(cap_val), 0);
      chk(cap_flag == 1'b0, "R8", "cap_flag after reset", int'(cap_flag), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule